// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. When one of its three trigger conditions is met, it drives a single high pulse on `pulse_o` whose length is a number of clock cycles taken from `width_i`. The complement appears on `pulse_n_o`. Each trigger is an edge on one input, and the pulse starts only when the other two inputs are at fixed levels. `trig_fall_i` triggers on a falling edge, and `trig_rise_i` triggers on a rising edge. The active-low clear `clr_n_i` forces the output low while it is held low, and its release, that is its rising edge, can itself start a pulse.

A valid trigger that arrives during a pulse restarts the full width from that point. A width of zero never produces a pulse. All three control inputs pass through two-flop synchronisers, and edges are detected on the synchronised values. For this reason the block can take inputs from another clock domain or from another one-shot.

Two instances can be chained by feeding the first pulse output into the falling-edge input of the second, with the second's rising-edge input held high. This gives a pulse of set width after a set delay.

Top module: `retrig_oneshot`

## Requirements
- R1: During reset and after its release with no trigger, `pulse_o` is 0 and `pulse_n_o` is 1. The synchronisers reset to the levels trig_fall_i=0, trig_rise_i=1, clr_n_i=1.
- R2: `pulse_n_o` is always the inverse of `pulse_o`.
- R3: A falling edge on `trig_fall_i`, with `trig_rise_i` high and `clr_n_i` high, starts a pulse. `pulse_o` goes high after the third rising clock edge after the input change, and stays high for exactly `width_i` cycles (width 1 gives one cycle).
- R4: A rising edge on `trig_rise_i`, with `trig_fall_i` low and `clr_n_i` high, starts a pulse with the same latency and length as R3.
- R5: A rising edge on `clr_n_i`, with `trig_fall_i` low and `trig_rise_i` high, starts a pulse. A rising edge on `clr_n_i` with `trig_fall_i` high, or with `trig_rise_i` low, starts none.
- R6: While `trig_fall_i` is high, a rising edge on `trig_rise_i` starts no pulse. While `trig_rise_i` is low, a falling edge on `trig_fall_i` starts no pulse. In both cases `pulse_o` stays low.
- R7: While `clr_n_i` is low, `pulse_o` is low from the second clock edge after it falls. This ends a running pulse, and no trigger starts a pulse during that time.
- R8: A valid trigger during an active pulse restarts the full width. The output stays high without a gap until `width_i` cycles after the retrigger, and it rises only after a detected trigger.
- R9: A trigger with `width_i` equal to 0 produces no pulse.
- R10: In a chain where the second instance takes the first's `pulse_o` on `trig_fall_i`, with `trig_rise_i` and `clr_n_i` held high, the second pulse rises 3 cycles after the first pulse falls and lasts the second instance's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_fall_i | input | 1 | Falling-edge trigger input |
| trig_rise_i | input | 1 | Rising-edge trigger input |
| clr_n_i | input | 1 | Active-low clear; its rising edge can trigger |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled when a trigger is taken |
| pulse_o | output | 1 | Pulse output, active high |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
The assertions take `width_i` as quasi-static: it does not change while a pulse runs, because the length bound is compared against its current value. They also assume that each input level lasts at least one clock, so the synchroniser turns every change into a single detected edge. The clear check looks back two cycles, so it only applies once two clock edges have passed since reset. The stimulus respects all of this. It changes the width only between pulses, it moves every input on the falling clock edge, and it holds each level for at least one full cycle.

// File: rtl/retrig_pkg.sv
// Shared constants for the retriggerable one-shot: positions of the three
// control levels inside the synchronised vector and their reset levels.
// Assumes nothing beyond a three-bit level vector.
package retrig_pkg;
    localparam int LVL_W  = 3;
    localparam int FALL_B = 2;   // falling-edge trigger level
    localparam int RISE_B = 1;   // rising-edge trigger level
    localparam int CLR_B  = 0;   // active-low clear level
    // Reset levels chosen so that no trigger is seen at reset release for
    // the common idle levels: fall input low, rise input high, clear high.
    localparam logic [LVL_W-1:0] LVL_RST = 3'b011;
endpackage

// File: rtl/oneshot_sync.sv
// Two-flop synchroniser for a vector of asynchronous levels.
// Each bit resets to its own value from RST_VAL. Assumes each input level
// is held for at least one clock so no change is lost.
module oneshot_sync #(
    parameter int                N       = 3,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one level bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/oneshot_trigger.sv
// Edge detector and qualifier. It compares synchronised levels with their
// previous values and raises fire_o for one cycle when any of the three
// qualified trigger conditions holds. arm_o is the synchronised clear level.
// Assumes lvl_i comes from a synchroniser with the same reset levels.
module oneshot_trigger
    import retrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             fire_o,
    output logic             arm_o
);
    logic [LVL_W-1:0] prev_q;
    logic             fall_hit, rise_hit, clr_hit;

    // Remember last cycle's synchronised levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LVL_RST;
        else        prev_q <= lvl_i;
    end

    // Qualified edge conditions (R3, R4, R5, R6).
    always_comb begin
        fall_hit = prev_q[FALL_B] & ~lvl_i[FALL_B] & lvl_i[RISE_B] & lvl_i[CLR_B];
        rise_hit = ~prev_q[RISE_B] & lvl_i[RISE_B] & ~lvl_i[FALL_B] & lvl_i[CLR_B];
        clr_hit  = ~prev_q[CLR_B] & lvl_i[CLR_B] & ~lvl_i[FALL_B] & lvl_i[RISE_B];
    end

    assign fire_o = fall_hit | rise_hit | clr_hit;
    assign arm_o  = lvl_i[CLR_B];
endmodule

// File: rtl/oneshot_timer.sv
// Down-counting width timer. A load sets the count to the width, and the
// output is active while the count is non-zero and the clear is released.
// Assumes width_i is stable while a load is taken.
module oneshot_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          load_i,
    input  logic [CW-1:0] width_i,
    output logic          active_o
);
    logic [CW-1:0] cnt_q;

    // Clear wins, then (re)load, then count down (R7, R8, R9).
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!arm_i)       cnt_q <= '0;
        else if (load_i)       cnt_q <= width_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Clear gates the output at once (R7).
    assign active_o = (cnt_q != '0) && arm_i;
endmodule

// File: rtl/retrig_oneshot.sv
// Retriggerable one-shot top level. The control inputs are synchronised,
// qualified into a single trigger strobe, and the strobe (re)loads the width
// timer. Assumes width_i changes only between pulses.
module retrig_oneshot
    import retrig_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_fall_i,
    input  logic               trig_rise_i,
    input  logic               clr_n_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o,
    output logic               pulse_n_o
);
    logic [LVL_W-1:0] raw_lvl, sync_lvl;
    logic             fire_w, arm_w, active_w;

    // Pack the control inputs at their fixed positions.
    always_comb begin
        raw_lvl         = '0;
        raw_lvl[FALL_B] = trig_fall_i;
        raw_lvl[RISE_B] = trig_rise_i;
        raw_lvl[CLR_B]  = clr_n_i;
    end

    oneshot_sync #(.N(LVL_W), .RST_VAL(LVL_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lvl),
        .q_o   (sync_lvl)
    );

    oneshot_trigger trig_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lvl),
        .fire_o (fire_w),
        .arm_o  (arm_w)
    );

    oneshot_timer #(.CW(WIDTH_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_w),
        .load_i   (fire_w),
        .width_i  (width_i),
        .active_o (active_w)
    );

    // Complementary outputs (R1, R2).
    assign pulse_o   = active_w;
    assign pulse_n_o = ~active_w;
endmodule

// File: rtl/retrig_oneshot_chk.sv
// Property checker for the one-shot, bound to every instance of the top.
// It observes the ports and the internal trigger strobe.
module retrig_oneshot_chk #(
    parameter int WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_n_i,
    input logic [WIDTH_W-1:0] width_i,
    input logic               fire,
    input logic               pulse_o
);
    logic [1:0]       age_q;    // edges since reset, saturating
    logic [WIDTH_W:0] since_q;  // cycles since last trigger, saturating

    // Count clock edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // Count cycles since the most recent trigger strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_q <= '0;
        else if (fire)          since_q <= {{WIDTH_W{1'b0}}, 1'b1};
        else if (since_q != '0 && since_q != '1) since_q <= since_q + 1'b1;
    end

    a_r7_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$past(clr_n_i, 2)) |-> !pulse_o);

    a_r9_no_zero_width_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> (width_i != '0));

    a_r3_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (since_q != '0 && since_q <= {1'b0, width_i}));

    a_r8_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire));
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.WIDTH_W(WIDTH_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n_i (clr_n_i),
    .width_i (width_i),
    .fire    (fire_w),
    .pulse_o (pulse_o)
);

// File: tb/retrig_oneshot_tb_top.sv
module retrig_oneshot_tb_top;
    localparam int WW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b1, b = 1'b0, c = 1'b1;
    logic [WW-1:0] w = 8'd5;
    logic q, qn, q2, qn2;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    retrig_oneshot #(.WIDTH_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_fall_i(a), .trig_rise_i(b),
        .clr_n_i(c), .width_i(w), .pulse_o(q), .pulse_n_o(qn)
    );

    // Second instance chained on the first's pulse (R10).
    retrig_oneshot #(.WIDTH_W(WW)) chain_i (
        .clk(clk), .rst_n(rst_n), .trig_fall_i(q), .trig_rise_i(1'b1),
        .clr_n_i(1'b1), .width_i(8'd4), .pulse_o(q2), .pulse_n_o(qn2)
    );

    typedef struct packed {
        logic [2:0] from;   // {a,b,clr}
        logic [2:0] to;
        logic [7:0] wid;
        logic       fires;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b111, 3'b011, 8'd5, 1'b1, 4'd3},  // R3 fall with rise high
        '{3'b101, 3'b001, 8'd5, 1'b0, 4'd6},  // R6 fall with rise low
        '{3'b001, 3'b011, 8'd7, 1'b1, 4'd4},  // R4 rise with fall low
        '{3'b101, 3'b111, 8'd7, 1'b0, 4'd6},  // R6 rise with fall high
        '{3'b010, 3'b011, 8'd4, 1'b1, 4'd5},  // R5 clear release triggers
        '{3'b110, 3'b111, 8'd4, 1'b0, 4'd5},  // R5 release with fall high
        '{3'b110, 3'b010, 8'd5, 1'b0, 4'd7},  // R7 fall while cleared
        '{3'b111, 3'b011, 8'd0, 1'b0, 4'd9},  // R9 zero width
        '{3'b111, 3'b011, 8'd1, 1'b1, 4'd3},  // R3 width of one
        '{3'b000, 3'b001, 8'd4, 1'b0, 4'd5}   // R5 release with rise low
    };

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lvl(input logic [2:0] v);
        {a, b, c} = v;
    endtask

    logic h1 [0:31];
    logic h2 [0:31];

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(q == 1'b0 && qn == 1'b1, "R1", q, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(q == 1'b0 && qn == 1'b1, "R1", q, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int cnt, first;
            bit qn_bad;
            set_lvl(3'b101);
            repeat (4) @(negedge clk);
            w = VECS[v].wid;
            set_lvl(VECS[v].from);
            repeat (24) @(negedge clk);
            set_lvl(VECS[v].to);
            cnt = 0; first = -1; qn_bad = 0;
            for (int i = 1; i <= int'(VECS[v].wid) + 10; i++) begin
                @(negedge clk);
                if (q) begin
                    cnt++;
                    if (first < 0) first = i;
                end
                if (qn == q) qn_bad = 1;
            end
            check(cnt == (VECS[v].fires ? int'(VECS[v].wid) : 0),
                  tname(VECS[v].tag), cnt, VECS[v].fires ? int'(VECS[v].wid) : 0);
            if (VECS[v].fires)
                check(first == 3, tname(VECS[v].tag), first, 3);
            check(!qn_bad, "R2", qn_bad, 0);
        end

        // R8: retrigger during the pulse
        begin
            int cnt;
            set_lvl(3'b111); w = 8'd6;
            repeat (24) @(negedge clk);
            a = 1'b0;
            cnt = 0;
            for (int i = 1; i < 32; i++) begin
                @(negedge clk);
                h1[i] = q;
                if (q) cnt++;
                if (i == 4) a = 1'b1;
                if (i == 5) a = 1'b0;
            end
            check(cnt == 11, "R8", cnt, 11);
            check(h1[13] == 1'b1, "R8", h1[13], 1);
            check(h1[14] == 1'b0, "R8", h1[14], 0);
        end

        // R7: clear ends a pulse; its release retriggers (R5)
        begin
            set_lvl(3'b111); w = 8'd10;
            repeat (24) @(negedge clk);
            a = 1'b0;
            for (int i = 1; i < 32; i++) begin
                @(negedge clk);
                h1[i] = q;
                if (i == 5) c = 1'b0;
                if (i == 9) c = 1'b1;
            end
            check(h1[6] == 1'b1, "R7", h1[6], 1);
            check(h1[7] == 1'b0, "R7", h1[7], 0);
            check(h1[11] == 1'b0, "R7", h1[11], 0);
            check(h1[12] == 1'b1, "R5", h1[12], 1);
            check(h1[21] == 1'b1, "R5", h1[21], 1);
            check(h1[22] == 1'b0, "R5", h1[22], 0);
        end

        // R10: chained delayed pulse
        begin
            int cnt2, first2, fall1;
            set_lvl(3'b111); w = 8'd5;
            repeat (24) @(negedge clk);
            a = 1'b0;
            cnt2 = 0; first2 = -1; fall1 = -1;
            for (int i = 1; i < 32; i++) begin
                @(negedge clk);
                h1[i] = q;
                h2[i] = q2;
                if (q2) begin
                    cnt2++;
                    if (first2 < 0) first2 = i;
                end
                if (fall1 < 0 && i > 1 && h1[i-1] && !q) fall1 = i;
            end
            check(cnt2 == 4, "R10", cnt2, 4);
            check(fall1 == 8, "R10", fall1, 8);
            check(first2 - fall1 == 3, "R10", first2 - fall1, 3);
            check(qn2 == ~q2, "R2", qn2, ~q2);
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule